// File: doc/BRIEF.md
# Quad-Data-Rate Burst SRAM Core

This block is a synchronous static memory with a read data path and a write data path that are fully separate, so a read burst and a write burst can stream out and in at the same time. Both kinds of request share one block-address bus. Every accepted request moves a burst of four 36-bit words. The two data edges of a double-data-rate interface are modelled at the single-clock level: each clock cycle carries a "rise" beat and a "fall" beat on separate bus halves, so one burst occupies two cycles on its data path.

A controller drives active-low read and write selects with a block address. The core accepts at most one request per clock edge and refuses the same kind of request on two edges in a row. A write that is still in flight is forwarded, lane by lane, to any read of the same block, so the controller never needs its own hazard logic. A static mode input sets the read latency to one clock or one and a half clocks.

Top module: `qdr_burst_sram`

## Requirements
- R1: A read burst may be leaving on the read outputs in the same cycles in which a write is accepted and its data is taken from the write inputs; neither path stalls the other.
- R2: An accepted request at block address B covers words 4*B+0, 4*B+1, 4*B+2 and 4*B+3, moved in that order; the two low word-address bits are never taken from the bus.
- R3: At most one request is accepted per clock edge, and the address bus belongs to that request. When both a read and a write are eligible on one edge, the kind that was not accepted most recently wins; after reset a read wins.
- R4: A read is never accepted on the edge right after an accepted read, and a write never on the edge right after an accepted write; such a request is dropped without touching memory or outputs.
- R5: Write beats 0 and 1 are taken from `wd_rise` and `wd_fall` on the edge that accepts the write, and beats 2 and 3 from the same inputs on the next edge.
- R6: Each 36-bit word has four 9-bit lanes, lane j at bits 9j+8 down to 9j. A write beat updates lane j only when bit j of its active-low lane enable (`wbe_rise_n` or `wbe_fall_n`, sampled with that beat) is 0; other lanes keep their contents.
- R7: A read of a block whose write was accepted on an earlier edge but is not yet stored (including a read on the edge carrying that write's beats 2 and 3) returns the new data, merged lane by lane with the old content by the lane enables.
- R8: With `lat_half` = 0, a read accepted on edge t shows beats 0 and 1 on the rise and fall halves of the cycle after edge t, and beats 2 and 3 on the two halves of the cycle after that.
- R9: With `lat_half` = 1, the same read is shifted by half a cycle: beat 0 on the fall half after edge t, beats 1 and 2 in the next cycle, beat 3 on the rise half of the third cycle; back-to-back reads never overlap.
- R10: `rq_vld_rise` and `rq_vld_fall` are high exactly for the beats of a read burst, and the matching data output reads zero whenever its valid flag is low.
- R11: After reset no read or write is pending, both valid flags are low and both read data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; all edges referred to are its rising edges |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_n | input | 1 | Active-low read request |
| wr_n | input | 1 | Active-low write request |
| addr | input | BLK_W | Block address shared by reads and writes |
| lat_half | input | 1 | Read latency select: 0 = one clock, 1 = one and a half clocks |
| wd_rise | input | 36 | Write data, first beat of the current cycle |
| wd_fall | input | 36 | Write data, second beat of the current cycle |
| wbe_rise_n | input | 4 | Active-low lane enables for `wd_rise` |
| wbe_fall_n | input | 4 | Active-low lane enables for `wd_fall` |
| rq_rise | output | 36 | Read data, first half of the cycle |
| rq_fall | output | 36 | Read data, second half of the cycle |
| rq_vld_rise | output | 1 | `rq_rise` carries a read beat |
| rq_vld_fall | output | 1 | `rq_fall` carries a read beat |

## Verification
The bench drives a read on the edge that carries a pending write's second data pair, and again on the edge where that write is being stored; a core without forwarding, or one that forwards only the first pair, returns stale lanes there. Held-low selects check that the second of two identical requests is dropped, and a read of the block named by a dropped write exposes a core that stores it anyway. Both selects held low together from reset check that reads and writes alternate with the read first, which an arbiter with fixed priority would break. Back-to-back reads in the half-cycle latency mode catch a beat queue that overwrites the last beat of one burst with the first of the next.

// File: rtl/qdr_burst_pkg.sv
package qdr_burst_pkg;

  localparam int LANE_W     = 9;
  localparam int LANES      = 4;
  localparam int WORD_W     = LANE_W * LANES;
  localparam int BEATS      = 4;
  localparam int BEAT_IDX_W = $clog2(BEATS);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANES-1:0]  lane_mask_t;
  typedef word_t      [BEATS-1:0] burst_t;
  typedef lane_mask_t [BEATS-1:0] burst_mask_t;

  typedef enum logic [1:0] {
    WB_IDLE = 2'd0,
    WB_HALF = 2'd1,
    WB_FULL = 2'd2
  } wb_state_e;

  // Replace the lanes of base selected by sel with those of upd.
  function automatic word_t lane_merge(word_t base, word_t upd, lane_mask_t sel);
    word_t res;
    res = base;
    for (int j = 0; j < LANES; j++) begin
      if (sel[j]) res[j*LANE_W +: LANE_W] = upd[j*LANE_W +: LANE_W];
    end
    return res;
  endfunction

  // Half-cycle slot (counted from the cycle after the accepting edge)
  // in which a given read beat appears.
  function automatic int beat_slot(logic half_step, int beat);
    return beat + (half_step ? 1 : 0);
  endfunction

  // Slots taken by one burst, as a bit mask over a queue of n slots.
  function automatic logic [15:0] burst_slot_mask(logic half_step);
    logic [15:0] m;
    m = '0;
    for (int k = 0; k < BEATS; k++) m[beat_slot(half_step, k)] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/qdr_burst_arbiter.sv
module qdr_burst_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_req,
  input  logic wr_req,
  output logic rd_acc,
  output logic wr_acc
);

  logic last_rd;
  logic last_wr;
  logic pref_rd;
  logic rd_ok;
  logic wr_ok;

  assign rd_ok  = rd_req && !last_rd;
  assign wr_ok  = wr_req && !last_wr;
  assign rd_acc = rd_ok && (!wr_ok || pref_rd);
  assign wr_acc = wr_ok && !rd_acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_rd <= 1'b0;
      last_wr <= 1'b0;
      pref_rd <= 1'b1;
    end else begin
      last_rd <= rd_acc;
      last_wr <= wr_acc;
      if (rd_acc)      pref_rd <= 1'b0;
      else if (wr_acc) pref_rd <= 1'b1;
    end
  end

  // R3: the shared address bus serves one request per edge
  p_single_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_acc && wr_acc));

  // R4: no read on the edge after a read
  p_no_rd_repeat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> !rd_acc);

  // R4: no write on the edge after a write
  p_no_wr_repeat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> !wr_acc);

  // R3: a read request that goes unserved while a write is taken is served next edge
  p_tie_goes_read_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && rd_req && !last_rd) ##1 rd_req |-> rd_acc);

endmodule

// File: rtl/qdr_burst_array.sv
module qdr_burst_array
  import qdr_burst_pkg::*;
#(
  parameter int BLK_W = 4
) (
  input  logic             clk,
  input  logic [BLK_W-1:0] rd_blk,
  output burst_t           rd_words,
  input  logic             we,
  input  logic [BLK_W-1:0] wr_blk,
  input  burst_t           wr_words,
  input  burst_mask_t      wr_mask
);

  localparam int NBLK  = 1 << BLK_W;
  localparam int DEPTH = NBLK * BEATS;

  word_t mem [DEPTH];

  for (genvar k = 0; k < BEATS; k++) begin : g_rd
    localparam logic [BEAT_IDX_W-1:0] KIDX = BEAT_IDX_W'(k);
    assign rd_words[k] = mem[{rd_blk, KIDX}];
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < BEATS; k++) begin
      for (int j = 0; j < LANES; j++) begin
        if (we && wr_mask[k][j])
          mem[{wr_blk, BEAT_IDX_W'(k)}][j*LANE_W +: LANE_W] <= wr_words[k][j*LANE_W +: LANE_W];
      end
    end
  end

endmodule

// File: rtl/qdr_burst_wbuf.sv
module qdr_burst_wbuf
  import qdr_burst_pkg::*;
#(
  parameter int BLK_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [BLK_W-1:0] blk,
  input  word_t            d_rise,
  input  word_t            d_fall,
  input  lane_mask_t       m_rise,
  input  lane_mask_t       m_fall,
  input  logic [BLK_W-1:0] look_blk,
  output logic             commit_en,
  output logic [BLK_W-1:0] commit_blk,
  output burst_t           commit_words,
  output burst_mask_t      commit_mask,
  output burst_t           fwd_words,
  output burst_mask_t      fwd_mask
);

  localparam int HALF_BEATS = BEATS / 2;

  wb_state_e        state;
  logic [BLK_W-1:0] b_blk;
  burst_t           b_words;
  burst_mask_t      b_mask;
  logic             hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= WB_IDLE;
    end else begin
      unique case (state)
        WB_IDLE: if (accept) state <= WB_HALF;
        WB_HALF: state <= WB_FULL;
        WB_FULL: state <= accept ? WB_HALF : WB_IDLE;
        default: state <= WB_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      b_blk      <= blk;
      b_words[0] <= d_rise;
      b_words[1] <= d_fall;
      b_mask[0]  <= m_rise;
      b_mask[1]  <= m_fall;
    end
    if (state == WB_HALF) begin
      b_words[2] <= d_rise;
      b_words[3] <= d_fall;
      b_mask[2]  <= m_rise;
      b_mask[3]  <= m_fall;
    end
  end

  assign commit_en    = (state == WB_FULL);
  assign commit_blk   = b_blk;
  assign commit_words = b_words;
  assign commit_mask  = b_mask;

  assign hit = (state != WB_IDLE) && (b_blk == look_blk);

  // First data pair always sits in the buffer once the write is pending;
  // the second pair is either buffered or arriving on this very edge.
  always_comb begin
    for (int k = 0; k < BEATS; k++) begin
      fwd_words[k] = b_words[k];
      fwd_mask[k]  = hit ? b_mask[k] : '0;
    end
    if (state == WB_HALF) begin
      fwd_words[HALF_BEATS]   = d_rise;
      fwd_words[HALF_BEATS+1] = d_fall;
      fwd_mask[HALF_BEATS]    = hit ? m_rise : '0;
      fwd_mask[HALF_BEATS+1]  = hit ? m_fall : '0;
    end
  end

  // R4: the arbiter never hands over a write while the second pair is due
  p_no_accept_mid_burst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WB_HALF) |-> !accept);

  // R11: nothing is pending in the first cycle after reset
  p_idle_after_reset_r11: assert property (@(posedge clk)
    !rst_n |=> (state == WB_IDLE));

endmodule

// File: rtl/qdr_burst_rpipe.sv
module qdr_burst_rpipe
  import qdr_burst_pkg::*;
#(
  parameter int SLOTS = 6
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  logic   lat_half,
  input  burst_t words,
  output word_t  beat_rise,
  output word_t  beat_fall,
  output logic   vld_rise,
  output logic   vld_fall
);

  localparam int SHIFT = 2;

  logic [SLOTS-1:0] sv;
  word_t            sd [SLOTS];
  logic [SLOTS-1:0] sh_v;
  word_t            sh_d [SLOTS];
  logic [SLOTS-1:0] nv;
  word_t            nd [SLOTS];
  logic [SLOTS-1:0] tgt;
  logic             overlap;

  // Advance the half-cycle queue by one clock (two slots).
  for (genvar i = 0; i < SLOTS; i++) begin : g_shift
    if (i + SHIFT < SLOTS) begin : g_mv
      assign sh_v[i] = sv[i+SHIFT];
      assign sh_d[i] = sd[i+SHIFT];
    end else begin : g_empty
      assign sh_v[i] = 1'b0;
      assign sh_d[i] = '0;
    end
  end

  assign tgt     = load ? burst_slot_mask(lat_half)[SLOTS-1:0] : '0;
  assign overlap = |(sh_v & tgt);

  always_comb begin
    nv = sh_v;
    for (int i = 0; i < SLOTS; i++) nd[i] = sh_d[i];
    if (load) begin
      for (int k = 0; k < BEATS; k++) begin
        nv[beat_slot(lat_half, k)] = 1'b1;
        nd[beat_slot(lat_half, k)] = words[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sv <= '0;
      for (int i = 0; i < SLOTS; i++) sd[i] <= '0;
    end else begin
      sv <= nv;
      for (int i = 0; i < SLOTS; i++) sd[i] <= nd[i];
    end
  end

  assign vld_rise  = sv[0];
  assign vld_fall  = sv[1];
  assign beat_rise = sd[0];
  assign beat_fall = sd[1];

  // R9: a new burst never lands on a beat still queued from the previous one
  p_slot_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !overlap);

  // R2: a loaded burst puts exactly four beats in flight
  p_four_beats_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && sv == '0) |=> ($countones(sv) == BEATS));

endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram
  import qdr_burst_pkg::*;
#(
  parameter int BLK_W = 4,
  parameter int SLOTS = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_n,
  input  logic                    wr_n,
  input  logic [BLK_W-1:0]        addr,
  input  logic                    lat_half,
  input  logic [WORD_W-1:0]       wd_rise,
  input  logic [WORD_W-1:0]       wd_fall,
  input  logic [LANES-1:0]        wbe_rise_n,
  input  logic [LANES-1:0]        wbe_fall_n,
  output logic [WORD_W-1:0]       rq_rise,
  output logic [WORD_W-1:0]       rq_fall,
  output logic                    rq_vld_rise,
  output logic                    rq_vld_fall
);

  logic             rd_acc;
  logic             wr_acc;
  burst_t           arr_words;
  burst_t           rd_words;
  logic             commit_en;
  logic [BLK_W-1:0] commit_blk;
  burst_t           commit_words;
  burst_mask_t      commit_mask;
  burst_t           fwd_words;
  burst_mask_t      fwd_mask;

  qdr_burst_arbiter u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_req (!rd_n),
    .wr_req (!wr_n),
    .rd_acc (rd_acc),
    .wr_acc (wr_acc)
  );

  qdr_burst_wbuf #(.BLK_W(BLK_W)) u_wbuf (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (wr_acc),
    .blk          (addr),
    .d_rise       (wd_rise),
    .d_fall       (wd_fall),
    .m_rise       (~wbe_rise_n),
    .m_fall       (~wbe_fall_n),
    .look_blk     (addr),
    .commit_en    (commit_en),
    .commit_blk   (commit_blk),
    .commit_words (commit_words),
    .commit_mask  (commit_mask),
    .fwd_words    (fwd_words),
    .fwd_mask     (fwd_mask)
  );

  qdr_burst_array #(.BLK_W(BLK_W)) u_array (
    .clk      (clk),
    .rd_blk   (addr),
    .rd_words (arr_words),
    .we       (commit_en),
    .wr_blk   (commit_blk),
    .wr_words (commit_words),
    .wr_mask  (commit_mask)
  );

  for (genvar k = 0; k < BEATS; k++) begin : g_merge
    assign rd_words[k] = lane_merge(arr_words[k], fwd_words[k], fwd_mask[k]);
  end

  qdr_burst_rpipe #(.SLOTS(SLOTS)) u_rpipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (rd_acc),
    .lat_half  (lat_half),
    .words     (rd_words),
    .beat_rise (rq_rise),
    .beat_fall (rq_fall),
    .vld_rise  (rq_vld_rise),
    .vld_fall  (rq_vld_fall)
  );

  // R5: a write is stored two edges after it is accepted
  p_commit_follows_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> ##1 commit_en);

  // R8: one-clock latency puts two beats out in the very next cycle
  p_lat_full_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && !lat_half) |=> (rq_vld_rise && rq_vld_fall));

  // R9: half-step latency starts on the fall half of the next cycle
  p_lat_half_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && lat_half) |=> rq_vld_fall);

  // R10: an empty half-cycle drives zero
  p_quiet_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rq_vld_rise |-> (rq_rise == '0));

  p_quiet_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rq_vld_fall |-> (rq_fall == '0));

endmodule

// File: tb/qdr_burst_sram_tb_top.sv
module qdr_burst_sram_tb_top;
  import qdr_burst_pkg::*;

  localparam int BLK_W   = 4;
  localparam int NBLK    = 1 << BLK_W;
  localparam int MAXS    = 48;
  localparam int MAXSLOT = 2 * (MAXS + 4);
  localparam int TAIL    = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n;
  logic             rd_n;
  logic             wr_n;
  logic [BLK_W-1:0] addr;
  logic             lat_half;
  word_t            wd_rise;
  word_t            wd_fall;
  lane_mask_t       wbe_rise_n;
  lane_mask_t       wbe_fall_n;
  word_t            rq_rise;
  word_t            rq_fall;
  logic             rq_vld_rise;
  logic             rq_vld_fall;

  qdr_burst_sram #(.BLK_W(BLK_W)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .addr        (addr),
    .lat_half    (lat_half),
    .wd_rise     (wd_rise),
    .wd_fall     (wd_fall),
    .wbe_rise_n  (wbe_rise_n),
    .wbe_fall_n  (wbe_fall_n),
    .rq_rise     (rq_rise),
    .rq_fall     (rq_fall),
    .rq_vld_rise (rq_vld_rise),
    .rq_vld_fall (rq_vld_fall)
  );

  int n_chk = 0;
  int n_bad = 0;
  int salt  = 1;
  bit done  = 1'b0;

  word_t      ref_mem [NBLK*BEATS];
  int         st_n;
  bit         st_rd  [MAXS];
  bit         st_wr  [MAXS];
  int         st_blk [MAXS];
  int         st_acc [MAXS];          // 0 none, 1 read, 2 write
  word_t      st_d   [MAXS][BEATS];
  lane_mask_t st_m   [MAXS][BEATS];   // active-high lane enables
  bit         exp_v  [MAXSLOT];
  word_t      exp_d  [MAXSLOT];
  bit         obs_v  [MAXSLOT];
  word_t      obs_d  [MAXSLOT];

  function automatic word_t pat(int blk, int k, int s);
    return (word_t'(s) * 36'h1_3579_BDF1) ^ (word_t'(blk) << 12) ^ (word_t'(k) << 4) ^ 36'h8_A5C3_0F69;
  endfunction

  task automatic seq_clear();
    st_n = 0;
  endtask

  task automatic add_step(bit rd, bit wr, int blk, int acc);
    st_rd[st_n]  = rd;
    st_wr[st_n]  = wr;
    st_blk[st_n] = blk;
    st_acc[st_n] = acc;
    for (int k = 0; k < BEATS; k++) begin
      st_d[st_n][k] = pat(blk, k, salt);
      st_m[st_n][k] = 4'hF;
    end
    salt++;
    st_n++;
  endtask

  task automatic set_masks(int idx, lane_mask_t m0, lane_mask_t m1, lane_mask_t m2, lane_mask_t m3);
    st_m[idx][0] = m0;
    st_m[idx][1] = m1;
    st_m[idx][2] = m2;
    st_m[idx][3] = m3;
  endtask

  task automatic drive_step(int i);
    if (i < st_n) begin
      rd_n = !st_rd[i];
      wr_n = !st_wr[i];
      addr = BLK_W'(st_blk[i]);
    end else begin
      rd_n = 1'b1;
      wr_n = 1'b1;
      addr = BLK_W'(i * 5);
    end
    if (i < st_n && st_acc[i] == 2) begin
      wd_rise    = st_d[i][0];
      wd_fall    = st_d[i][1];
      wbe_rise_n = ~st_m[i][0];
      wbe_fall_n = ~st_m[i][1];
    end else if (i > 0 && i - 1 < st_n && st_acc[i-1] == 2) begin
      wd_rise    = st_d[i-1][2];
      wd_fall    = st_d[i-1][3];
      wbe_rise_n = ~st_m[i-1][2];
      wbe_fall_n = ~st_m[i-1][3];
    end else begin
      wd_rise    = word_t'(i) * 36'h7_1111_1111;
      wd_fall    = ~(word_t'(i) * 36'h3_0F0F_0F0F);
      wbe_rise_n = 4'(i);
      wbe_fall_n = 4'(i + 3);
    end
  endtask

  // Build the expected beat stream from the requirements, run the
  // sequence, then compare every half-cycle slot.
  task automatic run_seq(string tag);
    int slots;
    int sl;
    slots = 2 * (st_n + TAIL);
    for (int s = 0; s < slots; s++) begin
      exp_v[s] = 1'b0;
      exp_d[s] = '0;
    end
    for (int i = 0; i < st_n; i++) begin
      if (st_acc[i] == 2) begin
        for (int k = 0; k < BEATS; k++)
          ref_mem[st_blk[i]*BEATS+k] = lane_merge(ref_mem[st_blk[i]*BEATS+k], st_d[i][k], st_m[i][k]);
      end else if (st_acc[i] == 1) begin
        for (int k = 0; k < BEATS; k++) begin
          sl = 2 * (i + 1) + (lat_half ? 1 : 0) + k;
          exp_v[sl] = 1'b1;
          exp_d[sl] = ref_mem[st_blk[i]*BEATS+k];
        end
      end
    end
    for (int i = 0; i < st_n + TAIL; i++) begin
      @(negedge clk);
      obs_v[2*i]   = rq_vld_rise;
      obs_d[2*i]   = rq_rise;
      obs_v[2*i+1] = rq_vld_fall;
      obs_d[2*i+1] = rq_fall;
      drive_step(i);
      @(posedge clk);
    end
    for (int s = 0; s < slots; s++) begin
      n_chk++;
      if (obs_v[s] != exp_v[s] || obs_d[s] != (exp_v[s] ? exp_d[s] : '0)) begin
        n_bad++;
        $display("FAIL %s slot %0d: valid %0b data %h, expected valid %0b data %h",
                 tag, s, obs_v[s], obs_d[s], exp_v[s], exp_v[s] ? exp_d[s] : '0);
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    rd_n  = 1'b1;
    wr_n  = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // R11 and R10: quiet outputs straight after reset
  task automatic t_reset();
    do_reset();
    seq_clear();
    run_seq("R11 reset idle");
  endtask

  // R5 and R6: fill every block with full-lane writes
  task automatic t_fill();
    lat_half = 1'b0;
    seq_clear();
    for (int b = 0; b < NBLK; b++) begin
      add_step(1'b0, 1'b1, b, 2);
      add_step(1'b0, 1'b0, 0, 0);
    end
    run_seq("R5 fill");
  endtask

  // R2 and R8: linear burst order at one-clock latency
  task automatic t_read_lat1();
    lat_half = 1'b0;
    seq_clear();
    for (int b = 0; b < 8; b++) begin
      add_step(1'b1, 1'b0, b, 1);
      add_step(1'b0, 1'b0, 0, 0);
    end
    run_seq("R2 R8 read one-clock");
  endtask

  // R9: back-to-back reads at half-step latency
  task automatic t_read_lat15();
    lat_half = 1'b1;
    seq_clear();
    for (int b = 8; b < NBLK; b++) begin
      add_step(1'b1, 1'b0, b, 1);
      add_step(1'b1, 1'b0, b, 0);
    end
    run_seq("R9 read half-step");
    lat_half = 1'b0;
  endtask

  // R4: repeated requests on consecutive edges are dropped
  task automatic t_repeat();
    lat_half = 1'b0;
    seq_clear();
    add_step(1'b1, 1'b0, 1, 1);
    add_step(1'b1, 1'b0, 2, 0);
    add_step(1'b1, 1'b0, 3, 1);
    add_step(1'b0, 1'b0, 0, 0);
    add_step(1'b0, 1'b1, 4, 2);
    add_step(1'b0, 1'b1, 5, 0);   // dropped write: block 5 must stay intact
    add_step(1'b0, 1'b0, 0, 0);
    add_step(1'b0, 1'b0, 0, 0);
    add_step(1'b1, 1'b0, 5, 1);
    add_step(1'b0, 1'b0, 0, 0);
    add_step(1'b1, 1'b0, 4, 1);
    run_seq("R4 repeat dropped");
  endtask

  // R6: lane enables on each of the four beats
  task automatic t_bytes();
    lat_half = 1'b0;
    seq_clear();
    add_step(1'b0, 1'b1, 6, 2);
    set_masks(0, 4'b0101, 4'b1010, 4'b0000, 4'b1001);
    add_step(1'b0, 1'b0, 0, 0);
    add_step(1'b0, 1'b0, 0, 0);
    add_step(1'b0, 1'b0, 0, 0);
    add_step(1'b1, 1'b0, 6, 1);
    run_seq("R6 lane enables");
  endtask

  // R7: forwarding from a pending write, in both latency modes
  task automatic t_forward(bit half, int b0, int b1, int b2, string tag);
    lat_half = half;
    seq_clear();
    add_step(1'b0, 1'b1, b0, 2);
    set_masks(0, 4'b0011, 4'b1100, 4'b0110, 4'b1111);
    add_step(1'b1, 1'b0, b0, 1);       // read on the edge carrying beats 2 and 3
    add_step(1'b0, 1'b0, 0, 0);
    add_step(1'b0, 1'b1, b1, 2);
    set_masks(3, 4'b1000, 4'b0001, 4'b1110, 4'b0100);
    add_step(1'b0, 1'b0, 0, 0);
    add_step(1'b1, 1'b0, b1, 1);       // read on the edge that stores the write
    add_step(1'b0, 1'b0, 0, 0);
    add_step(1'b0, 1'b1, b2, 2);
    add_step(1'b1, 1'b0, b2 + 1, 1);   // other block: must see no forwarding
    add_step(1'b0, 1'b0, 0, 0);
    run_seq(tag);
    lat_half = 1'b0;
  endtask

  // R1 and R3: both selects held low, alternation from reset
  task automatic t_concurrent();
    do_reset();
    lat_half = 1'b0;
    seq_clear();
    for (int i = 0; i < 8; i++) begin
      if (i % 2 == 0) add_step(1'b1, 1'b1, i / 2, 1);
      else            add_step(1'b1, 1'b1, 14 + (i / 2) % 2, 2);
    end
    add_step(1'b0, 1'b0, 0, 0);
    add_step(1'b1, 1'b0, 14, 1);
    add_step(1'b0, 1'b0, 0, 0);
    add_step(1'b1, 1'b0, 15, 1);
    add_step(1'b0, 1'b0, 0, 0);
    add_step(1'b1, 1'b1, 13, 2);       // after a read, a tie goes to the write
    add_step(1'b1, 1'b1, 12, 1);
    add_step(1'b0, 1'b0, 0, 0);
    add_step(1'b1, 1'b0, 13, 1);
    run_seq("R1 R3 concurrent alternation");
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    rst_n      = 1'b0;
    rd_n       = 1'b1;
    wr_n       = 1'b1;
    addr       = '0;
    lat_half   = 1'b0;
    wd_rise    = '0;
    wd_fall    = '0;
    wbe_rise_n = '1;
    wbe_fall_n = '1;
    for (int w = 0; w < NBLK*BEATS; w++) ref_mem[w] = '0;
    t_reset();
    t_fill();
    t_read_lat1();
    t_read_lat15();
    t_repeat();
    t_bytes();
    t_forward(1'b0, 7, 9, 10, "R7 forward one-clock");
    t_forward(1'b1, 11, 12, 2, "R7 R9 forward half-step");
    t_concurrent();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung, expected finished");
      report();
    end
  end

endmodule